// File: doc/BRIEF.md
# Line Sync and Border Interrupt Timer

This block is the free-running horizontal timing source for a display that software draws line by line. A counter on the master clock marks out each scan line. At the start of every line it raises a horizontal sync pulse and steps a three-bit pixel-row index that the character generator uses. The CPU takes no part in horizontal timing.

Software that runs during the top and bottom borders has to count lines. For that, the CPU can arm a non-maskable interrupt generator with a one-cycle enable strobe, and disarm it with a disable strobe. While armed, the block sends one short interrupt pulse per line, aligned with the rising edge of horizontal sync. Software disarms it before the active character rows and arms it again for the next border.

The block also merges the pixel bit with horizontal sync and the CPU-driven vertical sync request into a two-bit code for an external three-level DAC. The code has three values: sync (lowest), black and white (highest).

Top module: `line_sync_gen`

## Requirements
- R1: After reset is released, `hsyncOut` first rises 414 clock cycles later, and then rises every 414 cycles (parameter LINE_CYCLES).
- R2: Each `hsyncOut` pulse stays high for exactly 32 consecutive cycles (parameter SYNC_CYCLES).
- R3: Reset leaves the interrupt generator disarmed, and `nmiOut` stays 0 on every line while it is disarmed.
- R4: While the generator is armed, `nmiOut` is high for exactly 2 consecutive cycles per line (parameter NMI_CYCLES). The first of these is the cycle in which `hsyncOut` rises.
- R5: A one-cycle `nmiOnStb` arms the generator and a one-cycle `nmiOffStb` disarms it. When both are high in the same cycle, the generator ends up disarmed.
- R6: A strobe given in the last cycle before a line starts takes effect from the following line. An enable given there produces no pulse on the line that begins next. A disable given there still lets that line's pulse out.
- R7: `levelCode` is 2'b00 (sync) whenever `hsyncOut` or `vsyncReq` is high. Otherwise it is 2'b10 (white) when `pixelIn` is 1 and 2'b01 (black) when `pixelIn` is 0. It follows `pixelIn` and `vsyncReq` in the same cycle, and 2'b11 never appears.
- R8: `rowIdx` steps by one, modulo 8, in the same cycle that `hsyncOut` rises. It reads 0 from the first edge after `vsyncReq` is seen high, for as long as `vsyncReq` stays high.
- R9: During and right after reset, `hsyncOut` and `nmiOut` are 0 and `rowIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| nmiOnStb | input | 1 | One-cycle strobe that arms the interrupt generator |
| nmiOffStb | input | 1 | One-cycle strobe that disarms the interrupt generator |
| vsyncReq | input | 1 | Vertical sync request from the CPU, active high |
| pixelIn | input | 1 | Serial pixel bit, 1 = white |
| hsyncOut | output | 1 | Horizontal sync pulse |
| nmiOut | output | 1 | Non-maskable interrupt pulse |
| rowIdx | output | 3 | Pixel-row index within a character line |
| levelCode | output | 2 | DAC level: 00 sync, 01 black, 10 white |

## Verification
The arm or disarm command can arrive in the same cycle as the internal line-start event that would issue the interrupt. The bench finds the start of a line by watching the rising edge of `hsyncOut`, counts 413 cycles to reach the last cycle of that line, and pulses a strobe there. It then checks `nmiOut` in the cycle where the next `hsyncOut` rises and one line later. A late enable must give no pulse on the first line and then give a pulse, and a late disable must give one last pulse and then none. A second collision, between both strobes arriving together, is judged by the absence of a pulse on the following line.

// File: rtl/line_sync_pkg.sv
package line_sync_pkg;

  // Strobes from the line counter to the datapath
  typedef struct packed {
    logic lineStart;   // last cycle of a line: the next edge opens a new line
    logic syncEnd;     // last cycle of the sync pulse
  } line_strobe_t;

  typedef enum logic [1:0] {
    LVL_SYNC  = 2'b00,
    LVL_BLACK = 2'b01,
    LVL_WHITE = 2'b10
  } level_t;

endpackage

// File: rtl/line_sync_ctrl.sv
module line_sync_ctrl
  import line_sync_pkg::*;
#(
  parameter int LINE_CYCLES = 414,
  parameter int SYNC_CYCLES = 32
) (
  input  logic         clk,
  input  logic         rst,
  output line_strobe_t strobes
);

  localparam int CW = $clog2(LINE_CYCLES);
  localparam logic [CW-1:0] LAST_POS = CW'(LINE_CYCLES - 1);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_CYCLES - 1);

  logic [CW-1:0] linePos;

  always_ff @(posedge clk) begin
    if (rst) begin
      linePos <= '0;
    end else if (linePos == LAST_POS) begin
      linePos <= '0;
    end else begin
      linePos <= linePos + 1'b1;
    end
  end

  always_comb begin
    strobes.lineStart = (linePos == LAST_POS);
    strobes.syncEnd   = (linePos == SYNC_LAST);
  end

endmodule

// File: rtl/line_sync_dp.sv
module line_sync_dp
  import line_sync_pkg::*;
#(
  parameter int NMI_CYCLES = 2,
  parameter int ROW_BITS   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  line_strobe_t        strobes,
  input  logic                nmiOnStb,
  input  logic                nmiOffStb,
  input  logic                vsyncReq,
  input  logic                pixelIn,
  output logic                hsyncOut,
  output logic                nmiOut,
  output logic [ROW_BITS-1:0] rowIdx,
  output logic [1:0]          levelCode
);

  localparam int NW = $clog2(NMI_CYCLES + 1);
  localparam logic [NW-1:0] NMI_LOAD = NW'(NMI_CYCLES);

  logic          nmiArmed;
  logic [NW-1:0] nmiLeft;
  level_t        levelSel;

  // Sync pulse: opens with the line, closes after SYNC_CYCLES
  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncOut <= 1'b0;
    end else if (strobes.lineStart) begin
      hsyncOut <= 1'b1;
    end else if (strobes.syncEnd) begin
      hsyncOut <= 1'b0;
    end
  end

  // Arm state; disable wins over enable
  always_ff @(posedge clk) begin
    if (rst) begin
      nmiArmed <= 1'b0;
    end else if (nmiOffStb) begin
      nmiArmed <= 1'b0;
    end else if (nmiOnStb) begin
      nmiArmed <= 1'b1;
    end
  end

  // Pulse length counter, loaded at line start with the arm state held so far
  always_ff @(posedge clk) begin
    if (rst) begin
      nmiLeft <= '0;
    end else if (strobes.lineStart && nmiArmed) begin
      nmiLeft <= NMI_LOAD;
    end else if (nmiLeft != '0) begin
      nmiLeft <= nmiLeft - 1'b1;
    end
  end

  assign nmiOut = (nmiLeft != '0);

  // Pixel-row index stepped by the line start, held at zero in vertical sync
  always_ff @(posedge clk) begin
    if (rst || vsyncReq) begin
      rowIdx <= '0;
    end else if (strobes.lineStart) begin
      rowIdx <= rowIdx + 1'b1;
    end
  end

  always_comb begin
    if (hsyncOut || vsyncReq) begin
      levelSel = LVL_SYNC;
    end else if (pixelIn) begin
      levelSel = LVL_WHITE;
    end else begin
      levelSel = LVL_BLACK;
    end
  end

  assign levelCode = levelSel;

endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen
  import line_sync_pkg::*;
#(
  parameter int LINE_CYCLES = 414,
  parameter int SYNC_CYCLES = 32,
  parameter int NMI_CYCLES  = 2,
  parameter int ROW_BITS    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nmiOnStb,
  input  logic                nmiOffStb,
  input  logic                vsyncReq,
  input  logic                pixelIn,
  output logic                hsyncOut,
  output logic                nmiOut,
  output logic [ROW_BITS-1:0] rowIdx,
  output logic [1:0]          levelCode
);

  line_strobe_t strobes;

  line_sync_ctrl #(
    .LINE_CYCLES(LINE_CYCLES),
    .SYNC_CYCLES(SYNC_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  line_sync_dp #(
    .NMI_CYCLES(NMI_CYCLES),
    .ROW_BITS  (ROW_BITS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .nmiOnStb (nmiOnStb),
    .nmiOffStb(nmiOffStb),
    .vsyncReq (vsyncReq),
    .pixelIn  (pixelIn),
    .hsyncOut (hsyncOut),
    .nmiOut   (nmiOut),
    .rowIdx   (rowIdx),
    .levelCode(levelCode)
  );

endmodule

// File: rtl/line_sync_chk.sv
module line_sync_chk #(
  parameter int LINE_CYCLES = 414,
  parameter int SYNC_CYCLES = 32,
  parameter int ROW_BITS    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                vsyncReq,
  input logic                hsyncOut,
  input logic                nmiOut,
  input logic [ROW_BITS-1:0] rowIdx,
  input logic [1:0]          levelCode
);

  logic [15:0] highRun;
  logic [15:0] sinceRise;
  logic        prevH;
  logic        seenRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      highRun   <= '0;
      sinceRise <= '0;
      prevH     <= 1'b0;
      seenRise  <= 1'b0;
    end else begin
      highRun <= hsyncOut ? highRun + 16'd1 : 16'd0;
      prevH   <= hsyncOut;
      if (hsyncOut && !prevH) begin
        sinceRise <= 16'd1;
        seenRise  <= 1'b1;
      end else begin
        sinceRise <= sinceRise + 16'd1;
      end
    end
  end

  // R1
  line_period_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hsyncOut) && seenRise) |-> (sinceRise == 16'(LINE_CYCLES)));

  // R2
  sync_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hsyncOut) |-> (highRun == 16'(SYNC_CYCLES)));

  // R4
  nmi_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmiOut) |-> $rose(hsyncOut));

  // R4
  nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmiOut) |=> nmiOut);

  // R4
  nmi_end_chk: assert property (@(posedge clk) disable iff (rst)
    (nmiOut && $past(nmiOut)) |=> !nmiOut);

  // R7
  level_legal_chk: assert property (@(posedge clk) disable iff (rst)
    levelCode != 2'b11);

  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hsyncOut) && !vsyncReq && !$past(vsyncReq))
      |-> (rowIdx == $past(rowIdx) + 1'b1));

endmodule

bind line_sync_gen line_sync_chk #(
  .LINE_CYCLES(LINE_CYCLES),
  .SYNC_CYCLES(SYNC_CYCLES),
  .ROW_BITS   (ROW_BITS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .vsyncReq (vsyncReq),
  .hsyncOut (hsyncOut),
  .nmiOut   (nmiOut),
  .rowIdx   (rowIdx),
  .levelCode(levelCode)
);

// File: tb/tb_line_sync_gen.sv
module tb_line_sync_gen;

  localparam int CLK_PERIOD = 10;
  localparam int LINE = 414;
  localparam int SYNCW = 32;

  // Level vectors: {inSync, vsync, pixel, expected[1:0]}
  localparam logic [4:0] VEC [8] = '{
    5'b0_0_0_01, 5'b0_0_1_10, 5'b0_1_0_00, 5'b0_1_1_00,
    5'b1_0_0_00, 5'b1_0_1_00, 5'b1_1_0_00, 5'b1_1_1_00
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmiOnStb = 1'b0;
  logic       nmiOffStb = 1'b0;
  logic       vsyncReq = 1'b0;
  logic       pixelIn = 1'b0;
  logic       hsyncOut;
  logic       nmiOut;
  logic [2:0] rowIdx;
  logic [1:0] levelCode;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_sync_gen dut (
    .clk(clk), .rst(rst), .nmiOnStb(nmiOnStb), .nmiOffStb(nmiOffStb),
    .vsyncReq(vsyncReq), .pixelIn(pixelIn), .hsyncOut(hsyncOut),
    .nmiOut(nmiOut), .rowIdx(rowIdx), .levelCode(levelCode)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Returns at the first falling edge on which hsyncOut is high
  task automatic waitRise();
    while (hsyncOut) @(negedge clk);
    while (!hsyncOut) @(negedge clk);
  endtask

  // Counts nmi-high samples over one line starting at the current sample
  task automatic countLine(output int n);
    n = 0;
    for (int i = 0; i < LINE; i++) begin
      if (nmiOut) n++;
      @(negedge clk);
    end
  endtask

  // Drives a strobe in the last cycle of the current line; returns at the next rise sample
  task automatic strobeLate(input bit on, input bit off);
    waitRise();
    repeat (LINE - 1) @(negedge clk);
    nmiOnStb = on;
    nmiOffStb = off;
    @(negedge clk);
    nmiOnStb = 1'b0;
    nmiOffStb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n, t0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 hsync in reset", hsyncOut, 0);
    check("R9 nmi in reset", nmiOut, 0);
    check("R9 row in reset", rowIdx, 0);
    rst = 1'b0;

    // R1 first rise after reset release
    @(negedge clk);
    n = 1;
    while (!hsyncOut && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check("R1 first rise delay", n, LINE);

    // R2 width
    n = 0;
    while (hsyncOut) begin
      n++;
      @(negedge clk);
    end
    check("R2 sync width", n, SYNCW);

    // R1 period
    waitRise();
    t0 = 0;
    @(negedge clk);
    t0 = 1;
    while (!(hsyncOut && t0 > SYNCW)) begin
      @(negedge clk);
      t0++;
    end
    check("R1 line period", t0, LINE);

    // R3 disarmed after reset
    waitRise();
    countLine(n);
    check("R3 no nmi while disarmed", n, 0);

    // R4 armed mid-line: two cycles per line aligned to rise
    repeat (100) @(negedge clk);
    nmiOnStb = 1'b1;
    @(negedge clk);
    nmiOnStb = 1'b0;
    for (int l = 0; l < 3; l++) begin
      waitRise();
      check("R4 nmi at sync rise", nmiOut, 1);
      countLine(n);
      check("R4 nmi cycles per line", n, 2);
    end

    // R5 disarm mid-line
    repeat (100) @(negedge clk);
    nmiOffStb = 1'b1;
    @(negedge clk);
    nmiOffStb = 1'b0;
    waitRise();
    countLine(n);
    check("R5 no nmi after disarm", n, 0);

    // R6 late enable: not this line, next line yes
    strobeLate(1'b1, 1'b0);
    check("R6 late enable sync rise", hsyncOut, 1);
    countLine(n);
    check("R6 late enable first line", n, 0);
    check("R6 late enable next line", nmiOut, 1);

    // R6 late disable: this line still pulses, next line none
    strobeLate(1'b0, 1'b1);
    check("R6 late disable still pulses", nmiOut, 1);
    countLine(n);
    check("R6 late disable pulse count", n, 2);
    countLine(n);
    check("R6 late disable next line", n, 0);

    // R5 both strobes together disarm
    repeat (100) @(negedge clk);
    nmiOnStb = 1'b1;
    @(negedge clk);
    nmiOnStb = 1'b0;
    repeat (50) @(negedge clk);
    nmiOnStb = 1'b1;
    nmiOffStb = 1'b1;
    @(negedge clk);
    nmiOnStb = 1'b0;
    nmiOffStb = 1'b0;
    waitRise();
    countLine(n);
    check("R5 both strobes disarm", n, 0);

    // R7 level table
    foreach (VEC[i]) begin
      waitRise();
      if (!VEC[i][4]) repeat (SYNCW + 8) @(negedge clk);
      vsyncReq = VEC[i][3];
      pixelIn = VEC[i][2];
      #1;
      check("R7 level code", levelCode, int'(VEC[i][1:0]));
      vsyncReq = 1'b0;
    end
    pixelIn = 1'b0;

    // R8 vsync clears row, then steps and wraps
    waitRise();
    repeat (100) @(negedge clk);
    vsyncReq = 1'b1;
    @(negedge clk);
    check("R8 row cleared by vsync", rowIdx, 0);
    waitRise();
    check("R8 row held in vsync", rowIdx, 0);
    repeat (100) @(negedge clk);
    vsyncReq = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      waitRise();
      check("R8 row step", rowIdx, k % 8);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule